// File: doc/BRIEF.md
# Address Translation Unit with Page-Table Walker

This block turns virtual addresses into physical addresses. It keeps a small, fully associative cache of recent translations. Each request carries a virtual address and an access kind (read, write or execute). The page number is split off and looked up. A hit whose permission allows the access returns the physical frame joined to the unchanged page offset. A hit that forbids the access returns a protection fault without touching memory.

On a miss, an internal walker fetches one page-table entry through a request/response memory port. It sorts the entry into one of three faults, checked in a fixed priority. If the entry is usable, the walker writes it into the cache and replays the lookup, so a successful walk always finishes as a cache hit. The page-table base comes in on its own input. Only one translation is in flight at a time.

Top module: `xlat_mmu`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` and `mem_req_valid` are 0, and the translation cache is empty, so the first access to any page performs a walk.
- R2: A cached page whose permission allows the access responds with fault code 0 and `rsp_paddr` = {frame, vaddr[11:0]}. It issues no memory read, and `rsp_valid` rises two cycles after the request is accepted.
- R3: Access kinds are encoded 0 = read, 1 = write, 2 = execute, and code 3 is always denied. Page-table entry bit 2 grants read, bit 3 grants write and bit 4 grants execute. A cached page whose permission bit for the access is clear responds with fault code 2 (protection), `rsp_paddr` 0, and no memory read.
- R4: On a miss, exactly one memory read is issued, at address `ptbr` + (vaddr[31:12] * 4). The request address is held until `mem_req_ready` accepts it.
- R5: A fetched entry with bit 0 (valid) clear responds with fault code 1 (segmentation), whatever its other bits hold.
- R6: A valid entry whose permission forbids the access responds with fault code 2, even when its present bit (bit 1) is clear.
- R7: A valid, permitted entry with present bit 0 responds with fault code 3 (not present) and is not cached. Repeating the access walks again.
- R8: A valid, permitted, present entry is cached with frame bits 31:12 and permission bits 4:2. The access is then replayed and answers with fault 0 and the translated address. Later accesses to that page hit without a walk.
- R9: Once all 8 entries are filled, each new fill overwrites the entries in round-robin order. The order starts from slot 0 after reset and advances by one slot on every fill.
- R10: `req_ready` is low from the cycle after a request is accepted until the response has been given, so at most one request is outstanding.
- R11: `rsp_valid` is a single-cycle pulse. Whenever the fault code is nonzero, `rsp_paddr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual address |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| ptbr | input | 32 | Page-table base byte address |
| rsp_valid | output | 1 | Response pulse |
| rsp_paddr | output | 32 | Physical address, 0 on a fault |
| rsp_fault | output | 2 | 0 none, 1 segmentation, 2 protection, 3 not present |
| mem_req_valid | output | 1 | Page-table read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Page-table entry |

## Verification
The bench targets the fault priority with a page that is both unpermitted and absent. A design that checks the present bit first would report fault 3 where fault 2 is due. An absent page is accessed twice, so a design that caches absent entries shows up as a second access that makes no walk. A burst of fills wraps the replacement pointer and then probes which pages survived. An off-by-one pointer, or filling a free slot without advancing, evicts the wrong page and changes which accesses walk. The top page number checks the entry address arithmetic at full width. A reset in the middle of the run must empty the cache.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_SEG    = 2'd1,
        FLT_PROT   = 2'd2,
        FLT_ABSENT = 2'd3
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_WALK_REQ,
        ST_WALK_WAIT,
        ST_FILL,
        ST_RESP
    } wstate_e;

    // Entry layout positions consumed by the walker and the classifier
    localparam int PTE_V_BIT    = 0;
    localparam int PTE_P_BIT    = 1;
    localparam int PTE_PERM_LSB = 2;
    localparam int PERM_W       = 3;

    // perm[0] read, perm[1] write, perm[2] execute; reserved kind never allowed
    function automatic logic perm_ok(input logic [PERM_W-1:0] perm, input logic [1:0] acc);
        logic ok;
        case (acc)
            ACC_READ:  ok = perm[0];
            ACC_WRITE: ok = perm[1];
            ACC_EXEC:  ok = perm[2];
            default:   ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/xlat_tlb.sv
module xlat_tlb
    import xlat_pkg::*;
#(
    parameter int VPN_W = 20,
    parameter int PFN_W = 20,
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VPN_W-1:0]  lk_vpn,
    output logic              lk_hit,
    output logic [PFN_W-1:0]  lk_pfn,
    output logic [PERM_W-1:0] lk_perm,
    input  logic              fill_en,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic [PERM_W-1:0] fill_perm
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0]             vld;
        logic [DEPTH-1:0][VPN_W-1:0]  vpn;
        logic [DEPTH-1:0][PFN_W-1:0]  pfn;
        logic [DEPTH-1:0][PERM_W-1:0] perm;
        logic [IDX_W-1:0]             ptr;
    } tlb_t;

    tlb_t q, d;
    logic [DEPTH-1:0] hit_vec;

    // Parallel tag compare, one comparator per slot
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign hit_vec[i] = q.vld[i] && (q.vpn[i] == lk_vpn);
    end

    always_comb begin
        lk_hit  = |hit_vec;
        lk_pfn  = '0;
        lk_perm = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (hit_vec[i]) begin
                lk_pfn  = lk_pfn  | q.pfn[i];
                lk_perm = lk_perm | q.perm[i];
            end
        end
    end

    always_comb begin
        d = q;
        if (fill_en) begin
            d.vld[q.ptr]  = 1'b1;
            d.vpn[q.ptr]  = fill_vpn;
            d.pfn[q.ptr]  = fill_pfn;
            d.perm[q.ptr] = fill_perm;
            d.ptr         = (q.ptr == LAST_IDX) ? '0 : q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // A page is only filled after it missed, so two slots never match
    p_single_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // The slot just written must match its own page on the next lookup of it
    p_fill_visible_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> (q.vld[$past(q.ptr)] && q.vpn[$past(q.ptr)] == $past(fill_vpn)));

endmodule

// File: rtl/xlat_pte_check.sv
module xlat_pte_check
    import xlat_pkg::*;
(
    input  logic              pte_valid,
    input  logic              pte_present,
    input  logic [PERM_W-1:0] pte_perm,
    input  logic [1:0]        acc,
    output logic [1:0]        fault
);
    // Fixed priority: segmentation, then protection, then absence
    always_comb begin
        if (!pte_valid) begin
            fault = FLT_SEG;
        end else if (!perm_ok(pte_perm, acc)) begin
            fault = FLT_PROT;
        end else if (!pte_present) begin
            fault = FLT_ABSENT;
        end else begin
            fault = FLT_NONE;
        end
    end

endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
    import xlat_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int PAGE_W    = 12,
    parameter int PTE_W     = 32,
    parameter int PTE_BYTES = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [VA_W-1:0]        req_vaddr,
    input  logic [1:0]             req_acc,
    input  logic [VA_W-1:0]        ptbr,
    output logic                   rsp_valid,
    output logic [PA_W-1:0]        rsp_paddr,
    output logic [1:0]             rsp_fault,
    output logic                   mem_req_valid,
    input  logic                   mem_req_ready,
    output logic [VA_W-1:0]        mem_req_addr,
    input  logic                   mem_rsp_valid,
    input  logic [PTE_W-1:0]       mem_rsp_data,
    output logic [VA_W-PAGE_W-1:0] lk_vpn,
    input  logic                   lk_hit,
    input  logic [PA_W-PAGE_W-1:0] lk_pfn,
    input  logic [PERM_W-1:0]      lk_perm,
    output logic                   fill_en,
    output logic [VA_W-PAGE_W-1:0] fill_vpn,
    output logic [PA_W-PAGE_W-1:0] fill_pfn,
    output logic [PERM_W-1:0]      fill_perm,
    output logic                   chk_valid,
    output logic                   chk_present,
    output logic [PERM_W-1:0]      chk_perm,
    output logic [1:0]             chk_acc,
    input  logic [1:0]             chk_fault
);
    localparam int VPN_W  = VA_W - PAGE_W;
    localparam int PFN_W  = PA_W - PAGE_W;
    localparam int PTE_SH = $clog2(PTE_BYTES);

    typedef struct packed {
        wstate_e           st;
        logic [VA_W-1:0]   vaddr;
        logic [1:0]        acc;
        logic [PFN_W-1:0]  pfn;
        logic [PERM_W-1:0] perm;
        logic [PA_W-1:0]   paddr;
        logic [1:0]        fault;
    } walk_t;

    walk_t q, d;

    logic [VPN_W-1:0]  cur_vpn;
    logic [PAGE_W-1:0] cur_off;
    logic              unused_pte_bits;

    assign cur_vpn = q.vaddr[VA_W-1:PAGE_W];
    assign cur_off = q.vaddr[PAGE_W-1:0];

    // Entry fields seen by the classifier straight from the read data
    assign chk_valid   = mem_rsp_data[PTE_V_BIT];
    assign chk_present = mem_rsp_data[PTE_P_BIT];
    assign chk_perm    = mem_rsp_data[PTE_PERM_LSB +: PERM_W];
    assign chk_acc     = q.acc;
    assign unused_pte_bits = ^mem_rsp_data[PAGE_W-1:PTE_PERM_LSB+PERM_W];

    always_comb begin
        d       = q;
        fill_en = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st    = ST_LOOKUP;
                    d.vaddr = req_vaddr;
                    d.acc   = req_acc;
                end
            end
            ST_LOOKUP: begin
                if (lk_hit) begin
                    d.st = ST_RESP;
                    if (perm_ok(lk_perm, q.acc)) begin
                        d.paddr = {lk_pfn, cur_off};
                        d.fault = FLT_NONE;
                    end else begin
                        d.paddr = '0;
                        d.fault = FLT_PROT;
                    end
                end else begin
                    d.st = ST_WALK_REQ;
                end
            end
            ST_WALK_REQ: begin
                if (mem_req_ready) begin
                    d.st = ST_WALK_WAIT;
                end
            end
            ST_WALK_WAIT: begin
                if (mem_rsp_valid) begin
                    if (chk_fault != FLT_NONE) begin
                        d.st    = ST_RESP;
                        d.paddr = '0;
                        d.fault = chk_fault;
                    end else begin
                        d.st   = ST_FILL;
                        d.pfn  = mem_rsp_data[PAGE_W +: PFN_W];
                        d.perm = chk_perm;
                    end
                end
            end
            ST_FILL: begin
                fill_en = 1'b1;
                d.st    = ST_LOOKUP;
            end
            ST_RESP: begin
                d.st = ST_IDLE;
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign req_ready     = (q.st == ST_IDLE);
    assign rsp_valid     = (q.st == ST_RESP);
    assign rsp_paddr     = q.paddr;
    assign rsp_fault     = q.fault;
    assign mem_req_valid = (q.st == ST_WALK_REQ);
    assign mem_req_addr  = ptbr + (VA_W'(cur_vpn) << PTE_SH);
    assign lk_vpn        = cur_vpn;
    assign fill_vpn      = cur_vpn;
    assign fill_pfn      = q.pfn;
    assign fill_perm     = q.perm;

    p_one_outstanding_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_rsp_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_fault_zero_addr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault != FLT_NONE) |-> (rsp_paddr == '0));

    p_memreq_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    p_seg_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WALK_WAIT && mem_rsp_valid && !mem_rsp_data[PTE_V_BIT])
        |=> (rsp_valid && rsp_fault == FLT_SEG));

    p_absent_nofill_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WALK_WAIT && mem_rsp_valid && chk_fault == FLT_ABSENT) |=> !fill_en);

    p_replay_hits_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> lk_hit);

endmodule

// File: rtl/xlat_mmu.sv
module xlat_mmu
    import xlat_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int PAGE_W    = 12,
    parameter int PTE_W     = 32,
    parameter int PTE_BYTES = 4,
    parameter int TLB_DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [1:0]       req_acc,
    input  logic [VA_W-1:0]  ptbr,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_paddr,
    output logic [1:0]       rsp_fault,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [VA_W-1:0]  mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_data
);
    localparam int VPN_W = VA_W - PAGE_W;
    localparam int PFN_W = PA_W - PAGE_W;

    logic [VPN_W-1:0]  lk_vpn;
    logic              lk_hit;
    logic [PFN_W-1:0]  lk_pfn;
    logic [PERM_W-1:0] lk_perm;
    logic              fill_en;
    logic [VPN_W-1:0]  fill_vpn;
    logic [PFN_W-1:0]  fill_pfn;
    logic [PERM_W-1:0] fill_perm;
    logic              chk_valid;
    logic              chk_present;
    logic [PERM_W-1:0] chk_perm;
    logic [1:0]        chk_acc;
    logic [1:0]        chk_fault;

    xlat_tlb #(
        .VPN_W (VPN_W),
        .PFN_W (PFN_W),
        .DEPTH (TLB_DEPTH)
    ) u_tlb (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_vpn    (lk_vpn),
        .lk_hit    (lk_hit),
        .lk_pfn    (lk_pfn),
        .lk_perm   (lk_perm),
        .fill_en   (fill_en),
        .fill_vpn  (fill_vpn),
        .fill_pfn  (fill_pfn),
        .fill_perm (fill_perm)
    );

    xlat_pte_check u_check (
        .pte_valid   (chk_valid),
        .pte_present (chk_present),
        .pte_perm    (chk_perm),
        .acc         (chk_acc),
        .fault       (chk_fault)
    );

    xlat_walker #(
        .VA_W      (VA_W),
        .PA_W      (PA_W),
        .PAGE_W    (PAGE_W),
        .PTE_W     (PTE_W),
        .PTE_BYTES (PTE_BYTES)
    ) u_walker (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_vaddr     (req_vaddr),
        .req_acc       (req_acc),
        .ptbr          (ptbr),
        .rsp_valid     (rsp_valid),
        .rsp_paddr     (rsp_paddr),
        .rsp_fault     (rsp_fault),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .lk_vpn        (lk_vpn),
        .lk_hit        (lk_hit),
        .lk_pfn        (lk_pfn),
        .lk_perm       (lk_perm),
        .fill_en       (fill_en),
        .fill_vpn      (fill_vpn),
        .fill_pfn      (fill_pfn),
        .fill_perm     (fill_perm),
        .chk_valid     (chk_valid),
        .chk_present   (chk_present),
        .chk_perm      (chk_perm),
        .chk_acc       (chk_acc),
        .chk_fault     (chk_fault)
    );

    // Memory is never asked for an entry while a response is being given
    p_no_walk_at_rsp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req_valid && rsp_valid));

    p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (req_ready && !rsp_valid && !mem_req_valid));

endmodule

// File: tb/tb_xlat_mmu.sv
`timescale 1ns/1ps
module tb_xlat_mmu;

    localparam logic [31:0] PTBR = 32'h0001_0000;
    localparam int NVEC = 21;

    // {vaddr[68:37], acc[36:35], fault[34:33], walks[32], paddr[31:0]}
    localparam logic [68:0] VEC [NVEC] = '{
        {32'h00000123, 2'd0, 2'd0, 1'b1, 32'h00ABC123},
        {32'h00000FFF, 2'd0, 2'd0, 1'b0, 32'h00ABCFFF},
        {32'h00000004, 2'd1, 2'd2, 1'b0, 32'h00000000},
        {32'h00001008, 2'd1, 2'd0, 1'b1, 32'h12345008},
        {32'h00002000, 2'd0, 2'd1, 1'b1, 32'h00000000},
        {32'h00003010, 2'd1, 2'd2, 1'b1, 32'h00000000},
        {32'h00003010, 2'd0, 2'd3, 1'b1, 32'h00000000},
        {32'h00003010, 2'd0, 2'd3, 1'b1, 32'h00000000},
        {32'h00004ABC, 2'd2, 2'd0, 1'b1, 32'hFFFFFABC},
        {32'h00004ABC, 2'd0, 2'd2, 1'b0, 32'h00000000},
        {32'h00001FFC, 2'd0, 2'd0, 1'b0, 32'h12345FFC},
        {32'h00005010, 2'd0, 2'd0, 1'b1, 32'h00105010},
        {32'h00006010, 2'd0, 2'd0, 1'b1, 32'h00106010},
        {32'h00007010, 2'd0, 2'd0, 1'b1, 32'h00107010},
        {32'h00008010, 2'd0, 2'd0, 1'b1, 32'h00108010},
        {32'h00009010, 2'd0, 2'd0, 1'b1, 32'h00109010},
        {32'h0000A010, 2'd0, 2'd0, 1'b1, 32'h0010A010},
        {32'h00001000, 2'd0, 2'd0, 1'b0, 32'h12345000},
        {32'h00000000, 2'd0, 2'd0, 1'b1, 32'h00ABC000},
        {32'h00001004, 2'd0, 2'd0, 1'b1, 32'h12345004},
        {32'h00004000, 2'd2, 2'd0, 1'b1, 32'hFFFFF000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_acc = '0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic [1:0]  rsp_fault;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    int n_tests = 0;
    int n_fail  = 0;
    int walk_cnt = 0;
    logic [31:0] last_walk_addr = '0;
    logic [31:0] pt [16];

    always #10 clk = ~clk;

    xlat_mmu dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_vaddr     (req_vaddr),
        .req_acc       (req_acc),
        .ptbr          (PTBR),
        .rsp_valid     (rsp_valid),
        .rsp_paddr     (rsp_paddr),
        .rsp_fault     (rsp_fault),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data)
    );

    function automatic logic [31:0] mk_pte(input logic [19:0] pfn, input logic [2:0] perm,
                                           input logic present, input logic valid);
        return {pfn, 7'd0, perm, present, valid};
    endfunction

    function automatic logic [31:0] pte_at(input logic [31:0] addr);
        logic [31:0] idx;
        idx = (addr - PTBR) >> 2;
        if (addr >= PTBR && idx < 16) return pt[idx[3:0]];
        return 32'h0;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic do_req(input logic [31:0] va, input logic [1:0] acc,
                          output logic [1:0] f, output logic [31:0] pa,
                          output int lat, output logic busy_seen);
        @(negedge clk);
        req_vaddr = va;
        req_acc   = acc;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        busy_seen = !req_ready;
        lat = 1;
        while (!rsp_valid && lat < 60) begin
            @(negedge clk);
            lat++;
        end
        f  = rsp_fault;
        pa = rsp_paddr;
    endtask

    // Page-table memory: accepts one cycle late, answers two cycles later
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && mem_req_valid) begin
                walk_cnt++;
                last_walk_addr = mem_req_addr;
                mem_req_ready = 1'b1;
                @(negedge clk);
                mem_req_ready = 1'b0;
                @(negedge clk);
                mem_rsp_data  = pte_at(last_walk_addr);
                mem_rsp_valid = 1'b1;
                @(negedge clk);
                mem_rsp_valid = 1'b0;
                mem_rsp_data  = '0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [1:0]  f;
        logic [31:0] pa;
        int          lat;
        logic        busy;
        int          w0;
        string       tag;

        for (int i = 0; i < 16; i++) pt[i] = 32'h0;
        pt[0] = mk_pte(20'h00ABC, 3'b001, 1'b1, 1'b1);
        pt[1] = mk_pte(20'h12345, 3'b011, 1'b1, 1'b1);
        pt[2] = mk_pte(20'h55555, 3'b111, 1'b1, 1'b0);
        pt[3] = mk_pte(20'h00333, 3'b001, 1'b0, 1'b1);
        pt[4] = mk_pte(20'hFFFFF, 3'b100, 1'b1, 1'b1);
        for (int k = 5; k <= 10; k++) pt[k] = mk_pte(20'h00100 + 20'(k), 3'b111, 1'b1, 1'b1);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset
        check("R1", "req_ready", 32'(req_ready), 32'd1);
        check("R1", "rsp_valid", 32'(rsp_valid), 32'd0);
        check("R1", "mem_req_valid", 32'(mem_req_valid), 32'd0);

        for (int i = 0; i < NVEC; i++) begin
            logic [31:0] va, exp_pa;
            logic [1:0]  acc, exp_f;
            logic        exp_w;
            va     = VEC[i][68:37];
            acc    = VEC[i][36:35];
            exp_f  = VEC[i][34:33];
            exp_w  = VEC[i][32];
            exp_pa = VEC[i][31:0];
            if (i >= 17)            tag = "R9";
            else if (!exp_w)        tag = (exp_f == 2'd0) ? "R2" : "R3";
            else if (exp_f == 2'd1) tag = "R5";
            else if (exp_f == 2'd2) tag = "R6";
            else if (exp_f == 2'd3) tag = "R7";
            else                    tag = "R8";
            w0 = walk_cnt;
            do_req(va, acc, f, pa, lat, busy);
            check(tag, $sformatf("vec%0d fault", i), 32'(f), 32'(exp_f));
            check(tag, $sformatf("vec%0d paddr", i), pa, exp_pa);
            check(tag, $sformatf("vec%0d walks", i), 32'(walk_cnt - w0), 32'(exp_w));
            check("R10", $sformatf("vec%0d busy", i), 32'(busy), 32'd1);
            if (exp_w) begin
                // R4: entry address = base + page number * 4
                check("R4", $sformatf("vec%0d walk addr", i), last_walk_addr,
                      PTBR + ((va >> 12) << 2));
            end else begin
                check("R2", $sformatf("vec%0d hit latency", i), 32'(lat), 32'd2);
            end
            @(negedge clk);
            check("R11", $sformatf("vec%0d pulse", i), 32'(rsp_valid), 32'd0);
        end

        // R4: top page number, full-width address arithmetic; entry reads 0 -> segmentation
        w0 = walk_cnt;
        do_req(32'hFFFFF123, 2'd0, f, pa, lat, busy);
        check("R4", "top page walk addr", last_walk_addr, 32'h0040FFFC);
        check("R5", "top page fault", 32'(f), 32'd1);
        check("R11", "top page paddr", pa, 32'h0);

        // R3: reserved access kind is denied on a cached page (vpn1 cached, rw)
        w0 = walk_cnt;
        do_req(32'h00001000, 2'd3, f, pa, lat, busy);
        check("R3", "reserved kind fault", 32'(f), 32'd2);
        check("R3", "reserved kind no walk", 32'(walk_cnt - w0), 32'd0);

        // R1: reset empties the cache
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "req_ready after reset", 32'(req_ready), 32'd1);
        w0 = walk_cnt;
        do_req(32'h00001000, 2'd0, f, pa, lat, busy);
        check("R1", "walk after reset", 32'(walk_cnt - w0), 32'd1);
        check("R8", "paddr after reset", pa, 32'h12345000);
        // R9: pointer restarts at slot 0; vpn1 now lives there and hits
        w0 = walk_cnt;
        do_req(32'h00001ABC, 2'd1, f, pa, lat, busy);
        check("R9", "hit after refill", 32'(walk_cnt - w0), 32'd0);
        check("R2", "write hit paddr", pa, 32'h12345ABC);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule